// File: doc/BRIEF.md
# Word FIFO Pair with Self-Clearing Flush

This block holds two queues of 32-bit words between a register bus and a serial bus engine. Words written by software go into the transmit queue, and the engine drains them from there. The engine pushes received words into the receive queue, and software reads them out from there. Each word carries four bytes.

A control register sets a trigger level for each queue and holds a flush bit for each. A flush bit stays at 1 until the hardware has emptied that queue, then drops to 0, so software can poll it. A status register reports free transmit slots and filled receive slots as packed 4-bit counts, next to two sticky error flags.

Two request outputs compare those counts against the trigger levels and tell the surrounding logic when software should refill or drain a queue.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset, both queues are empty, the status register reads 0x080, the control register reads 0, and both sticky flags are clear.
- R2: Register word addresses are 0 for control, 1 for status, 2 for the transmit data port (write) and 3 for the receive data port (read). Words leave each queue in the order they entered it, across pointer wrap.
- R3: Status bits 3:0 hold the number of filled receive entries, bits 7:4 the number of free transmit entries, bit 8 the sticky transmit overflow and bit 9 the sticky receive underflow. Each count stays within 0..8.
- R4: Control bit 0 flushes the receive queue and bit 1 flushes the transmit queue, and one write may set both. The bit reads 1 in the cycle after the write, the queue is empty after the following clock edge, and the bit reads 0 one edge later.
- R5: While a queue's flush bit reads 1, pushes and pops on that queue have no effect.
- R6: Control bits 4:2 hold the receive trigger and bits 7:5 hold the transmit trigger. Both read back as written.
- R7: rx_req is high exactly when the filled receive count is greater than the receive trigger.
- R8: tx_req is high exactly when the free transmit count is greater than the transmit trigger.
- R9: A bus write to a full transmit queue is dropped and sets the overflow flag. Only a transmit flush clears that flag.
- R10: A bus read from an empty receive queue returns 0 and sets the underflow flag. Only a receive flush clears that flag.
- R11: eng_tx_valid is low when the transmit queue is empty. eng_rx_full is high when the receive queue holds 8 words, and an engine push in that state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_full | output | 1 | Receive queue full |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |

## Verification
The hardest case to reach is a push or pop that lands inside the short window while a flush is still pending. The bench reaches it by issuing queue operations on the very next cycles after the control write, back to back, so that they hit both the clearing edge and the following edge. The transmit queue is also filled to capacity only after earlier traffic has moved its pointers, so the overflow case runs across pointer wrap.

// File: rtl/wfp_pkg.sv
package wfp_pkg;

  localparam int WORD_W = 32;
  localparam int DEPTH  = 8;
  localparam int TRIG_W = 3;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_TXD  = 2'd2,
    ADR_RXD  = 2'd3
  } reg_addr_e;

  // request comparison: level strictly above the trigger
  function automatic logic level_above(input logic [3:0] level,
                                       input logic [TRIG_W-1:0] trig);
    return level > {1'b0, trig};
  endfunction

  function automatic logic [3:0] slots_free(input logic [3:0] depth,
                                            input logic [3:0] filled);
    return depth - filled;
  endfunction

  function automatic logic [31:0] pack_status(input logic [3:0] rx_fill,
                                              input logic [3:0] tx_free,
                                              input logic       ovf,
                                              input logic       udf);
    logic [31:0] r;
    r      = '0;
    r[3:0] = rx_fill;
    r[7:4] = tx_free;
    r[8]   = ovf;
    r[9]   = udf;
    return r;
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic rx_busy,
                                            input logic tx_busy,
                                            input logic [TRIG_W-1:0] rx_trig,
                                            input logic [TRIG_W-1:0] tx_trig);
    logic [31:0] r;
    r      = '0;
    r[0]   = rx_busy;
    r[1]   = tx_busy;
    r[4:2] = rx_trig;
    r[7:5] = tx_trig;
    return r;
  endfunction

endpackage

// File: rtl/wfp_word_fifo.sv
module wfp_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_drop,
  output logic             pop_miss
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push & ~full & ~hold;
  assign pop_ok    = pop & ~empty & ~hold;
  assign push_drop = push & full & ~hold;
  assign pop_miss  = pop & empty & ~hold;
  assign head      = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/wfp_flush_seq.sv
module wfp_flush_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic clr
);

  logic pend, done;

  assign busy = pend;
  assign clr  = pend & ~done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= pend & ~done & ~start;
      pend <= start | (pend & ~done);
    end
  end

endmodule

// File: rtl/wfp_ctrl_regs.sv
module wfp_ctrl_regs
  import wfp_pkg::*;
#(
  parameter int NQ = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  output logic [TRIG_W-1:0] rx_trig,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [NQ-1:0]     busy,
  output logic [NQ-1:0]     clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig <= '0;
      tx_trig <= '0;
    end else if (ctrl_wr) begin
      rx_trig <= ctrl_wdata[4:2];
      tx_trig <= ctrl_wdata[7:5];
    end
  end

  // index 0 serves the receive queue, index 1 the transmit queue
  for (genvar q = 0; q < NQ; q++) begin : g_flush
    wfp_flush_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ctrl_wr & ctrl_wdata[q]),
      .busy  (busy[q]),
      .clr   (clr[q])
    );
  end

endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
  import wfp_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int DEPTH = wfp_pkg::DEPTH,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         eng_tx_pop,
  output logic [W-1:0] eng_tx_data,
  output logic         eng_tx_valid,
  input  logic         eng_rx_push,
  input  logic [W-1:0] eng_rx_data,
  output logic         eng_rx_full,
  output logic         tx_req,
  output logic         rx_req
);

  localparam int RXQ = 0;
  localparam int TXQ = 1;

  logic [TRIG_W-1:0] rx_trig, tx_trig;
  logic [1:0]        busy, clr;
  logic              tx_busy, rx_busy, tx_clr, rx_clr;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push_drop, tx_pop_miss, rx_push_drop, rx_pop_miss;
  logic [W-1:0]      rx_head;
  logic              ctrl_wr, tx_wr, rx_rd;
  logic              tx_ovf, rx_udf;
  logic [3:0]        rx_fill4, tx_free4;

  assign ctrl_wr = bus_wr & (bus_addr == ADR_CTRL);
  assign tx_wr   = bus_wr & (bus_addr == ADR_TXD);
  assign rx_rd   = bus_rd & (bus_addr == ADR_RXD);

  assign rx_busy = busy[RXQ];
  assign tx_busy = busy[TXQ];
  assign rx_clr  = clr[RXQ];
  assign tx_clr  = clr[TXQ];

  wfp_ctrl_regs #(.NQ(2)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (bus_wdata[7:0]),
    .rx_trig    (rx_trig),
    .tx_trig    (tx_trig),
    .busy       (busy),
    .clr        (clr)
  );

  wfp_word_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tx_clr),
    .hold      (tx_busy),
    .push      (tx_wr),
    .push_data (bus_wdata),
    .pop       (eng_tx_pop),
    .head      (eng_tx_data),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_drop (tx_push_drop),
    .pop_miss  (tx_pop_miss)
  );

  wfp_word_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .hold      (rx_busy),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (rx_rd),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_drop (rx_push_drop),
    .pop_miss  (rx_pop_miss)
  );

  // sticky error flags, cleared only by the matching flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_udf <= 1'b0;
    end else begin
      if (tx_clr)            tx_ovf <= 1'b0;
      else if (tx_push_drop) tx_ovf <= 1'b1;
      if (rx_clr)            rx_udf <= 1'b0;
      else if (rx_pop_miss)  rx_udf <= 1'b1;
    end
  end

  assign rx_fill4     = 4'(rx_count);
  assign tx_free4     = slots_free(4'(DEPTH), 4'(tx_count));
  assign rx_req       = level_above(rx_fill4, rx_trig);
  assign tx_req       = level_above(tx_free4, tx_trig);
  assign eng_tx_valid = ~tx_empty;
  assign eng_rx_full  = rx_full;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: bus_rdata = W'(pack_ctrl(rx_busy, tx_busy, rx_trig, tx_trig));
      ADR_STAT: bus_rdata = W'(pack_status(rx_fill4, tx_free4, tx_ovf, rx_udf));
      ADR_RXD:  bus_rdata = (rx_empty | rx_busy) ? '0 : rx_head;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wfp_checker.sv
module wfp_checker #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_clr,
  input logic             rx_clr,
  input logic             tx_busy,
  input logic             rx_busy,
  input logic             tx_push_drop,
  input logic             tx_pop_miss,
  input logic             rx_push_drop,
  input logic             rx_pop_miss,
  input logic             tx_ovf,
  input logic             rx_udf,
  input logic [W-1:0]     bus_rdata,
  input logic             rx_req,
  input logic             tx_req,
  input logic             eng_tx_valid,
  input logic             eng_rx_full
);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

  // R4
  tx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_count == '0) && tx_busy);

  // R4
  rx_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_count == '0) && rx_busy);

  // R4
  tx_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_clr, 2));

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> (tx_count == '0));

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && $past(rx_busy)) |-> (rx_count == '0));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_drop |=> tx_ovf);

  // R10
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_miss |-> (bus_rdata == '0));

  // R10
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_miss |=> rx_udf);

  // R7
  rx_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_count != '0));

  // R8
  tx_req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CNT_W'(DEPTH)) |-> !tx_req);

  // R11
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_miss |-> !eng_tx_valid);

  // R11
  rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_drop |-> eng_rx_full);

endmodule

bind word_fifo_pair wfp_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_count     (tx_count),
  .rx_count     (rx_count),
  .tx_clr       (tx_clr),
  .rx_clr       (rx_clr),
  .tx_busy      (tx_busy),
  .rx_busy      (rx_busy),
  .tx_push_drop (tx_push_drop),
  .tx_pop_miss  (tx_pop_miss),
  .rx_push_drop (rx_push_drop),
  .rx_pop_miss  (rx_pop_miss),
  .tx_ovf       (tx_ovf),
  .rx_udf       (rx_udf),
  .bus_rdata    (bus_rdata),
  .rx_req       (rx_req),
  .tx_req       (tx_req),
  .eng_tx_valid (eng_tx_valid),
  .eng_rx_full  (eng_rx_full)
);

// File: tb/tb_word_fifo_pair.sv
module tb_word_fifo_pair;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_tx_pop = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_tx_valid;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        eng_rx_full;
  logic        tx_req, rx_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  word_fifo_pair dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
    .tx_req(tx_req), .rx_req(rx_req)
  );

  // op codes: 0 bus tx write, 1 engine rx push, 2 bus rx read,
  //           3 status read, 4 engine tx pop
  localparam logic [66:0] VEC [16] = '{
    {3'd0, 32'h11111111, 32'h0},
    {3'd0, 32'h22222222, 32'h0},
    {3'd3, 32'h0,        32'h00000060},
    {3'd4, 32'h0,        32'h11111111},
    {3'd1, 32'hAAAA0001, 32'h0},
    {3'd1, 32'hAAAA0002, 32'h0},
    {3'd1, 32'hAAAA0003, 32'h0},
    {3'd3, 32'h0,        32'h00000073},
    {3'd2, 32'h0,        32'hAAAA0001},
    {3'd4, 32'h0,        32'h22222222},
    {3'd2, 32'h0,        32'hAAAA0002},
    {3'd0, 32'h33333333, 32'h0},
    {3'd2, 32'h0,        32'hAAAA0003},
    {3'd3, 32'h0,        32'h00000070},
    {3'd4, 32'h0,        32'h33333333},
    {3'd3, 32'h0,        32'h00000080}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic eng_pop(output logic [31:0] d);
    eng_tx_pop = 1'b1;
    #1 d = eng_tx_data;
    @(negedge clk);
    eng_tx_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd1, rd); check("R1 R3 status after reset", rd, 32'h80);
    bus_read(2'd0, rd); check("R1 control after reset", rd, 32'h0);
    check("R8 tx_req at reset", {31'b0, tx_req}, 32'd1);
    check("R7 rx_req at reset", {31'b0, rx_req}, 32'd0);
    check("R11 tx valid at reset", {31'b0, eng_tx_valid}, 32'd0);

    // R2 R3 vector table
    for (int i = 0; i < 16; i++) begin
      logic [2:0]  op;
      logic [31:0] d, e;
      {op, d, e} = VEC[i];
      case (op)
        3'd0: bus_write(2'd2, d);
        3'd1: eng_push(d);
        3'd2: begin bus_read(2'd3, rd); check("R2 rx order", rd, e); end
        3'd3: begin bus_read(2'd1, rd); check("R3 status counts", rd, e); end
        default: begin eng_pop(rd); check("R2 tx order", rd, e); end
      endcase
    end

    // R9 overflow across pointer wrap
    for (int i = 0; i < 8; i++) bus_write(2'd2, 32'h100 + i);
    bus_read(2'd1, rd); check("R3 tx full status", rd, 32'h00);
    check("R8 tx_req when full", {31'b0, tx_req}, 32'd0);
    bus_write(2'd2, 32'hDEADBEEF);
    bus_read(2'd1, rd); check("R9 overflow flag", rd, 32'h100);
    for (int i = 0; i < 8; i++) begin
      eng_pop(rd); check("R9 R2 drained word", rd, 32'h100 + i);
    end
    check("R11 tx valid after drain", {31'b0, eng_tx_valid}, 32'd0);
    bus_read(2'd1, rd); check("R9 flag sticky", rd, 32'h180);

    // R4 transmit flush timing, flag clear
    bus_write(2'd2, 32'h77);
    bus_write(2'd0, 32'h2);
    bus_read(2'd0, rd); check("R4 tx flush bit set", rd, 32'h2);
    bus_read(2'd1, rd); check("R4 R9 tx emptied flag cleared", rd, 32'h80);
    bus_read(2'd0, rd); check("R4 tx flush bit clear", rd, 32'h0);

    // R10 underflow
    bus_read(2'd3, rd); check("R10 empty read zero", rd, 32'h0);
    bus_read(2'd1, rd); check("R10 underflow flag", rd, 32'h280);
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, rd); check("R4 rx flush bit set", rd, 32'h1);
    bus_read(2'd0, rd); check("R4 rx flush still pending", rd, 32'h1);
    bus_read(2'd1, rd); check("R10 underflow cleared", rd, 32'h80);

    // R6 R7 R8 triggers: rx trig 2, tx trig 7
    bus_write(2'd0, 32'hE8);
    bus_read(2'd0, rd); check("R6 trigger readback", rd, 32'hE8);
    check("R8 tx_req free8 trig7", {31'b0, tx_req}, 32'd1);
    eng_push(32'h1); eng_push(32'h2);
    check("R7 rx_req at trig", {31'b0, rx_req}, 32'd0);
    eng_push(32'h3);
    check("R7 rx_req above trig", {31'b0, rx_req}, 32'd1);
    bus_write(2'd2, 32'h9);
    check("R8 tx_req free7 trig7", {31'b0, tx_req}, 32'd0);

    // R5 both flushes at once, traffic during the pending window
    bus_write(2'd0, 32'hEB);
    eng_push(32'h55);
    bus_write(2'd2, 32'h66);
    bus_read(2'd0, rd); check("R4 both flush bits clear", rd, 32'hE8);
    bus_read(2'd1, rd); check("R5 pushes ignored during flush", rd, 32'h80);

    // R11 receive full
    for (int i = 0; i < 9; i++) eng_push(32'hC00 + i);
    check("R11 rx full", {31'b0, eng_rx_full}, 32'd1);
    bus_read(2'd1, rd); check("R11 ninth push dropped", rd, 32'h88);
    bus_read(2'd3, rd); check("R11 R2 first rx word", rd, 32'hC00);

    finished = 1'b1;
    finish_run();
  end

endmodule